// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a host bus and the control logic of a single 1M x 8 flash device. It watches host write cycles, takes the address and data present when write-enable returns high while the device is selected, and interprets the data byte as a command opcode. Single-cycle commands change what a host read returns: array contents, the two identifier bytes, or a status byte. Two-cycle commands (erase and byte write) are matched as setup/confirm pairs and become operation requests to a separate write engine.

The write engine is outside this block. Requests go to it on a valid/ready channel: once `req_valid` is high, kind, address and data stay frozen until the engine takes them with `req_ready`, and back-pressure simply stretches the pending request. The engine reports completion with a one-cycle `eng_done` pulse (with `eng_fail`) and holds `eng_suspended` high while an erase is paused. The programming voltage is a single digital flag, `vpp_high`. Host control inputs are sampled into the system clock domain through a synchronizer before any edge is detected.

Reads are combinational: `host_rdata` follows the current read mode and `host_addr` at once.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the read mode is array read (`host_rdata` equals `arr_rdata`), `req_valid` is low and the status byte reads 80h.
- R2: Opcode FFh selects array read; opcode 90h selects identifier mode, where an even address reads 89h and an odd address reads A2h until another accepted command is written.
- R3: Opcode 70h selects status read and opcode 50h clears status bits 5, 4 and 3 without changing the read mode; both work with `vpp_high` low. Status layout: bit 7 ready, bit 6 erase suspended, bit 5 erase error, bit 4 write error, bit 3 low programming voltage, bits 2..0 zero.
- R4: Opcode 20h followed by D0h to an address in the same block (top 4 address bits) with `vpp_high` set issues one erase request (kind 0) carrying the confirm address, and reads return status with bit 7 clear.
- R5: Opcode 40h or 10h followed by any write with `vpp_high` set issues one byte-write request (kind 1) carrying that write's address and data; reads return status.
- R6: While a byte write runs, only 70h is acted on; FFh and every other opcode leave the read mode unchanged.
- R7: During an erase, B0h issues a suspend request (kind 2). While the engine reports suspended, status reads C0h, only FFh, 70h and D0h are acted on, and D0h issues a resume request (kind 3) and selects status read.
- R8: An erase setup followed by any byte other than D0h, or by D0h to a different block, issues no request and sets status bits 5 and 4.
- R9: A confirm or write-data cycle while `vpp_high` is low issues no request and sets status bit 3.
- R10: Opcodes outside the defined set leave the read mode unchanged and issue no request.
- R11: In array mode during a suspended erase, reads within the suspended block return FFh; reads elsewhere return `arr_rdata`.
- R12: A write-enable pulse while chip-enable is high is not taken as a command.
- R13: While `req_valid` is high and `req_ready` low, the request stays valid with kind, address and data unchanged.
- R14: An `eng_done` pulse ends the operation (status bit 7 set); with `eng_fail` it sets bit 5 after an erase or bit 4 after a byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | 8 | Host write data / opcode |
| host_rdata | output | 8 | Read data selected by the read mode |
| arr_rdata | input | 8 | Array data at `host_addr` |
| vpp_high | input | 1 | Programming voltage present |
| req_valid | output | 1 | Engine request valid |
| req_ready | input | 1 | Engine accepts request |
| req_kind | output | 2 | 0 erase, 1 write, 2 suspend, 3 resume |
| req_addr | output | ADDR_W | Request address |
| req_data | output | 8 | Byte-write data |
| eng_done | input | 1 | Engine operation finished (pulse) |
| eng_fail | input | 1 | Finished operation failed |
| eng_suspended | input | 1 | Engine erase paused |

## Verification
A host write becomes visible three clock edges after write-enable rises: two synchronizer stages, then the command register; `req_valid` rises on that same edge and drops one edge after the handshake. The bench holds write-enable low and then high for three cycles each and waits a further five before any read or request check, so every check samples settled state. Reads are combinational, so read checks set the address and sample one time step later, away from the clock edge; handshakes are counted on the falling edge preceding the accepting rising edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_STATUS} rd_mode_e;
  typedef enum logic [1:0] {OP_NONE, OP_ERASE, OP_WRITE} op_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ERASE_SETUP, SQ_WRITE_SETUP} seq_e;
  typedef enum logic [1:0] {RK_ERASE, RK_WRITE, RK_SUSPEND, RK_RESUME} req_kind_e;

  localparam logic [BYTE_W-1:0] OPC_ARRAY     = 8'hFF;
  localparam logic [BYTE_W-1:0] OPC_IDENT     = 8'h90;
  localparam logic [BYTE_W-1:0] OPC_STATUS    = 8'h70;
  localparam logic [BYTE_W-1:0] OPC_CLEAR     = 8'h50;
  localparam logic [BYTE_W-1:0] OPC_ERASE     = 8'h20;
  localparam logic [BYTE_W-1:0] OPC_CONFIRM   = 8'hD0;
  localparam logic [BYTE_W-1:0] OPC_WRITE_A   = 8'h40;
  localparam logic [BYTE_W-1:0] OPC_WRITE_B   = 8'h10;
  localparam logic [BYTE_W-1:0] OPC_SUSPEND   = 8'hB0;
  localparam logic [BYTE_W-1:0] ID_MAKER      = 8'h89;
  localparam logic [BYTE_W-1:0] ID_PART       = 8'hA2;
  localparam logic [BYTE_W-1:0] HIDDEN_BYTE   = 8'hFF;

endpackage

// File: rtl/fcd_host_sync.sv
module fcd_host_sync #(
  parameter int ADDR_W      = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ce_n,
  input  logic                                we_n,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [flash_cmd_pkg::BYTE_W-1:0]    wdata,
  output logic                                wr_stb,
  output logic [ADDR_W-1:0]                   wr_addr,
  output logic [flash_cmd_pkg::BYTE_W-1:0]    wr_data
);
  import flash_cmd_pkg::*;

  localparam int DEPTH = SYNC_STAGES + 1;
  localparam int PW    = ADDR_W + BYTE_W;

  // control chain: index DEPTH-2 is the current synchronized sample,
  // index DEPTH-1 the sample one cycle earlier
  logic [1:0]    ctl [DEPTH];
  logic [PW-1:0] pay [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ctl[g] <= 2'b11;
          pay[g] <= '0;
        end else begin
          ctl[g] <= {ce_n, we_n};
          pay[g] <= {addr, wdata};
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ctl[g] <= 2'b11;
          pay[g] <= '0;
        end else begin
          ctl[g] <= ctl[g-1];
          pay[g] <= pay[g-1];
        end
      end
    end
  end

  logic cur_we_n, prv_we_n, prv_ce_n;
  assign cur_we_n = ctl[DEPTH-2][0];
  assign prv_we_n = ctl[DEPTH-1][0];
  assign prv_ce_n = ctl[DEPTH-1][1];

  // rising write-enable while selected: take the last sample before the rise
  assign wr_stb  = !prv_we_n && cur_we_n && !prv_ce_n;
  assign wr_addr = pay[DEPTH-1][PW-1:BYTE_W];
  assign wr_data = pay[DEPTH-1][BYTE_W-1:0];

endmodule

// File: rtl/fcd_cmd_seq.sv
module fcd_cmd_seq #(
  parameter int ADDR_W  = 20,
  parameter int BLOCK_W = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_stb,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [flash_cmd_pkg::BYTE_W-1:0] wr_data,
  input  logic                             vpp_high,
  input  logic                             req_ready,
  input  logic                             eng_done,
  input  logic                             eng_suspended,
  output flash_cmd_pkg::rd_mode_e          rd_mode,
  output flash_cmd_pkg::op_e               op,
  output logic                             suspended,
  output logic [BLOCK_W-1:0]               erase_blk,
  output logic                             req_valid,
  output flash_cmd_pkg::req_kind_e         req_kind,
  output logic [ADDR_W-1:0]                req_addr,
  output logic [flash_cmd_pkg::BYTE_W-1:0] req_data,
  output logic                             ev_improper,
  output logic                             ev_vpp_low,
  output logic                             ev_clear
);
  import flash_cmd_pkg::*;

  seq_e                 seq, seq_n;
  rd_mode_e             mode_n;
  op_e                  op_n;
  logic [BLOCK_W-1:0]   setup_blk, setup_blk_n, erase_blk_n;
  logic                 rv_n;
  req_kind_e            rk_n;
  logic [ADDR_W-1:0]    ra_n;
  logic [BYTE_W-1:0]    rd_n;
  logic [BLOCK_W-1:0]   wr_blk;

  assign wr_blk    = wr_addr[ADDR_W-1 -: BLOCK_W];
  assign suspended = (op == OP_ERASE) && eng_suspended;

  always_comb begin
    seq_n       = seq;
    mode_n      = rd_mode;
    op_n        = op;
    setup_blk_n = setup_blk;
    erase_blk_n = erase_blk;
    rv_n        = req_valid && !req_ready;
    rk_n        = req_kind;
    ra_n        = req_addr;
    rd_n        = req_data;
    ev_improper = 1'b0;
    ev_vpp_low  = 1'b0;
    ev_clear    = 1'b0;

    if (eng_done) op_n = OP_NONE;

    if (wr_stb) begin
      unique case (seq)
        SQ_ERASE_SETUP: begin
          seq_n  = SQ_IDLE;
          mode_n = RM_STATUS;
          if (wr_data == OPC_CONFIRM && wr_blk == setup_blk) begin
            if (vpp_high) begin
              rv_n        = 1'b1;
              rk_n        = RK_ERASE;
              ra_n        = wr_addr;
              rd_n        = '0;
              op_n        = OP_ERASE;
              erase_blk_n = wr_blk;
            end else begin
              ev_vpp_low = 1'b1;
            end
          end else begin
            ev_improper = 1'b1;
          end
        end
        SQ_WRITE_SETUP: begin
          seq_n  = SQ_IDLE;
          mode_n = RM_STATUS;
          if (vpp_high) begin
            rv_n = 1'b1;
            rk_n = RK_WRITE;
            ra_n = wr_addr;
            rd_n = wr_data;
            op_n = OP_WRITE;
          end else begin
            ev_vpp_low = 1'b1;
          end
        end
        default: begin
          if (op == OP_WRITE) begin
            if (wr_data == OPC_STATUS) mode_n = RM_STATUS;
          end else if (suspended) begin
            if (wr_data == OPC_ARRAY) begin
              mode_n = RM_ARRAY;
            end else if (wr_data == OPC_STATUS) begin
              mode_n = RM_STATUS;
            end else if (wr_data == OPC_CONFIRM && !req_valid) begin
              mode_n = RM_STATUS;
              rv_n   = 1'b1;
              rk_n   = RK_RESUME;
              ra_n   = '0;
              rd_n   = '0;
            end
          end else if (op == OP_ERASE) begin
            if (wr_data == OPC_STATUS) begin
              mode_n = RM_STATUS;
            end else if (wr_data == OPC_SUSPEND && !req_valid) begin
              mode_n = RM_STATUS;
              rv_n   = 1'b1;
              rk_n   = RK_SUSPEND;
              ra_n   = '0;
              rd_n   = '0;
            end
          end else begin
            unique case (wr_data)
              OPC_ARRAY:  mode_n = RM_ARRAY;
              OPC_IDENT:  mode_n = RM_IDENT;
              OPC_STATUS: mode_n = RM_STATUS;
              OPC_CLEAR:  ev_clear = 1'b1;
              OPC_ERASE: begin
                seq_n       = SQ_ERASE_SETUP;
                setup_blk_n = wr_blk;
                mode_n      = RM_STATUS;
              end
              OPC_WRITE_A, OPC_WRITE_B: begin
                seq_n  = SQ_WRITE_SETUP;
                mode_n = RM_STATUS;
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq       <= SQ_IDLE;
      rd_mode   <= RM_ARRAY;
      op        <= OP_NONE;
      setup_blk <= '0;
      erase_blk <= '0;
      req_valid <= 1'b0;
      req_kind  <= RK_ERASE;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      seq       <= seq_n;
      rd_mode   <= mode_n;
      op        <= op_n;
      setup_blk <= setup_blk_n;
      erase_blk <= erase_blk_n;
      req_valid <= rv_n;
      req_kind  <= rk_n;
      req_addr  <= ra_n;
      req_data  <= rd_n;
    end
  end

endmodule

// File: rtl/fcd_status.sv
module fcd_status (
  input  logic                             clk,
  input  logic                             rst_n,
  input  flash_cmd_pkg::op_e               op,
  input  logic                             suspended,
  input  logic                             ev_improper,
  input  logic                             ev_vpp_low,
  input  logic                             ev_clear,
  input  logic                             eng_done,
  input  logic                             eng_fail,
  output logic [flash_cmd_pkg::BYTE_W-1:0] status
);
  import flash_cmd_pkg::*;

  logic err_erase, err_write, err_vpp;
  logic fail_now;

  assign fail_now = eng_done && eng_fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_erase <= 1'b0;
      err_write <= 1'b0;
      err_vpp   <= 1'b0;
    end else if (ev_clear) begin
      err_erase <= 1'b0;
      err_write <= 1'b0;
      err_vpp   <= 1'b0;
    end else begin
      err_erase <= err_erase | ev_improper | (fail_now && op == OP_ERASE);
      err_write <= err_write | ev_improper | (fail_now && op == OP_WRITE);
      err_vpp   <= err_vpp | ev_vpp_low;
    end
  end

  logic ready;
  assign ready  = (op == OP_NONE) || suspended;
  assign status = {ready, suspended, err_erase, err_write, err_vpp, 3'b000};

endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux #(
  parameter int BLOCK_W = 4
) (
  input  flash_cmd_pkg::rd_mode_e          rd_mode,
  input  logic [BLOCK_W-1:0]               rd_blk,
  input  logic                             rd_lsb,
  input  logic [flash_cmd_pkg::BYTE_W-1:0] arr_rdata,
  input  logic [flash_cmd_pkg::BYTE_W-1:0] status,
  input  logic                             suspended,
  input  logic [BLOCK_W-1:0]               erase_blk,
  output logic [flash_cmd_pkg::BYTE_W-1:0] rdata
);
  import flash_cmd_pkg::*;

  always_comb begin
    unique case (rd_mode)
      RM_IDENT:  rdata = rd_lsb ? ID_PART : ID_MAKER;
      RM_STATUS: rdata = status;
      default:   rdata = (suspended && rd_blk == erase_blk) ? HIDDEN_BYTE : arr_rdata;
    endcase
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W      = 20,
  parameter int BLOCK_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_ce_n,
  input  logic              host_we_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [7:0]        arr_rdata,
  input  logic              vpp_high,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data,
  input  logic              eng_done,
  input  logic              eng_fail,
  input  logic              eng_suspended
);
  import flash_cmd_pkg::*;

  logic                wr_stb;
  logic [ADDR_W-1:0]   wr_addr;
  logic [BYTE_W-1:0]   wr_data;
  rd_mode_e            rd_mode;
  op_e                 op;
  logic                suspended;
  logic [BLOCK_W-1:0]  erase_blk;
  req_kind_e           kind;
  logic                ev_improper, ev_vpp_low, ev_clear;
  logic [BYTE_W-1:0]   status;

  fcd_host_sync #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(host_ce_n), .we_n(host_we_n),
    .addr(host_addr), .wdata(host_wdata),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fcd_cmd_seq #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .vpp_high(vpp_high), .req_ready(req_ready),
    .eng_done(eng_done), .eng_suspended(eng_suspended),
    .rd_mode(rd_mode), .op(op), .suspended(suspended), .erase_blk(erase_blk),
    .req_valid(req_valid), .req_kind(kind), .req_addr(req_addr),
    .req_data(req_data), .ev_improper(ev_improper), .ev_vpp_low(ev_vpp_low),
    .ev_clear(ev_clear)
  );

  fcd_status u_status (
    .clk(clk), .rst_n(rst_n), .op(op), .suspended(suspended),
    .ev_improper(ev_improper), .ev_vpp_low(ev_vpp_low), .ev_clear(ev_clear),
    .eng_done(eng_done), .eng_fail(eng_fail), .status(status)
  );

  fcd_read_mux #(.BLOCK_W(BLOCK_W)) u_rmux (
    .rd_mode(rd_mode), .rd_blk(host_addr[ADDR_W-1 -: BLOCK_W]),
    .rd_lsb(host_addr[0]), .arr_rdata(arr_rdata), .status(status),
    .suspended(suspended), .erase_blk(erase_blk), .rdata(host_rdata)
  );

  assign req_kind = kind;

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W  = 20,
  parameter int BLOCK_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [1:0]              req_kind,
  input logic [ADDR_W-1:0]       req_addr,
  input logic [7:0]              req_data,
  input flash_cmd_pkg::rd_mode_e rd_mode,
  input flash_cmd_pkg::op_e      op,
  input logic                    suspended,
  input logic [BLOCK_W-1:0]      rd_blk,
  input logic                    rd_lsb,
  input logic [BLOCK_W-1:0]      erase_blk,
  input logic [7:0]              host_rdata,
  input logic                    wr_stb,
  input logic [7:0]              wr_data
);
  import flash_cmd_pkg::*;

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_kind) &&
                                $stable(req_addr) && $stable(req_data));

  assert_ident_bytes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode == RM_IDENT |-> host_rdata == (rd_lsb ? 8'hA2 : 8'h89));

  assert_hidden_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode == RM_ARRAY && suspended && rd_blk == erase_blk |-> host_rdata == 8'hFF);

  assert_write_locks_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_WRITE && wr_stb && wr_data != 8'h70 |=> $stable(rd_mode));

  assert_erase_reads_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'd0 |-> rd_mode == RM_STATUS);

  assert_suspend_ignores_ident_R7: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && wr_stb && wr_data == 8'h90 |=> $stable(rd_mode));

  assert_status_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode == RM_STATUS |-> host_rdata[2:0] == 3'b000);

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
  .rd_mode(rd_mode), .op(op), .suspended(suspended),
  .rd_blk(host_addr[ADDR_W-1 -: BLOCK_W]), .rd_lsb(host_addr[0]),
  .erase_blk(erase_blk), .host_rdata(host_rdata), .wr_stb(wr_stb),
  .wr_data(wr_data)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int BLOCK_W    = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_ce_n = 1'b1;
  logic              host_we_n = 1'b1;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [7:0]        host_wdata = '0;
  logic [7:0]        host_rdata;
  logic [7:0]        arr_rdata;
  logic              vpp_high = 1'b1;
  logic              req_valid;
  logic              req_ready = 1'b1;
  logic [1:0]        req_kind;
  logic [ADDR_W-1:0] req_addr;
  logic [7:0]        req_data;
  logic              eng_done = 1'b0;
  logic              eng_fail = 1'b0;
  logic              eng_suspended = 1'b0;

  int checks = 0;
  int errors = 0;
  int hs_count = 0;
  logic [1:0]        last_kind = '0;
  logic [ADDR_W-1:0] last_addr = '0;
  logic [7:0]        last_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] arr_of(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ 8'h5A ^ {a[ADDR_W-1 -: BLOCK_W], 4'h3};
  endfunction
  assign arr_rdata = arr_of(host_addr);

  flash_cmd_decoder #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .host_ce_n(host_ce_n), .host_we_n(host_we_n),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .arr_rdata(arr_rdata), .vpp_high(vpp_high), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_addr(req_addr),
    .req_data(req_data), .eng_done(eng_done), .eng_fail(eng_fail),
    .eng_suspended(eng_suspended)
  );

  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      hs_count  <= hs_count + 1;
      last_kind <= req_kind;
      last_addr <= req_addr;
      last_data <= req_data;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [ADDR_W-1:0] a, input logic [7:0] d, input bit sel = 1'b1);
    @(negedge clk);
    host_addr  = a;
    host_wdata = d;
    host_ce_n  = !sel;
    @(negedge clk);
    host_we_n = 1'b0;
    repeat (3) @(negedge clk);
    host_we_n = 1'b1;
    repeat (3) @(negedge clk);
    host_ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [7:0] exp);
    host_addr = a;
    #1;
    chk(tag, host_rdata, exp);
  endtask

  task automatic finish_op(input bit fail);
    @(posedge clk); #1;
    eng_done = 1'b1; eng_fail = fail;
    @(posedge clk); #1;
    eng_done = 1'b0; eng_fail = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] sweep_exp(input logic [7:0] opc, input logic [ADDR_W-1:0] a);
    if (opc == 8'h90) return a[0] ? 8'hA2 : 8'h89;
    if (opc == 8'h70) return 8'h80;
    return arr_of(a);
  endfunction

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 req_valid", req_valid, 0);
    rd_chk("R1 array read", 20'h3_0003, arr_of(20'h3_0003));
    host_write('0, 8'h70);
    rd_chk("R1 status after reset", '0, 8'h80);

    // R2 R3 R10 opcode sweep from array mode
    for (int opc = 0; opc < 256; opc++) begin
      if (opc == 8'h20 || opc == 8'h40 || opc == 8'h10) continue;
      host_write('0, 8'hFF);
      host_write(20'h1_2340, opc[7:0]);
      rd_chk($sformatf("R2 R10 op %02h addr0", opc), 20'h0_0000, sweep_exp(opc[7:0], 20'h0_0000));
      rd_chk($sformatf("R2 R10 op %02h addr1", opc), 20'h0_0001, sweep_exp(opc[7:0], 20'h0_0001));
      chk($sformatf("R10 no request op %02h", opc), hs_count, 0);
    end

    // R12 write while deselected
    host_write('0, 8'hFF);
    host_write('0, 8'h90, 1'b0);
    rd_chk("R12 deselected write ignored", 20'h0_0000, arr_of(20'h0_0000));

    // R3 status commands with low programming voltage
    vpp_high = 1'b0;
    host_write('0, 8'h70);
    rd_chk("R3 status at low vpp", '0, 8'h80);
    vpp_high = 1'b1;

    // R4 R14 erase every block
    for (int b = 0; b < 16; b++) begin
      base = hs_count;
      host_write({b[3:0], 16'h1234}, 8'h20);
      host_write({b[3:0], 16'hABCD}, 8'hD0);
      chk($sformatf("R4 erase count blk %0d", b), hs_count, base + 1);
      chk($sformatf("R4 erase kind blk %0d", b), last_kind, 0);
      chk($sformatf("R4 erase addr blk %0d", b), last_addr, {b[3:0], 16'hABCD});
      rd_chk($sformatf("R4 busy status blk %0d", b), '0, 8'h00);
      finish_op(b == 7);
      rd_chk($sformatf("R14 erase done blk %0d", b), '0, (b == 7) ? 8'hA0 : 8'h80);
      if (b == 7) begin
        host_write('0, 8'h50);
        rd_chk("R3 clear after erase fail", '0, 8'h80);
      end
    end

    // R5 R6 R14 byte write with both setup codes
    for (int k = 0; k < 4; k++) begin
      logic [7:0] sc;
      logic [ADDR_W-1:0] wa;
      logic [7:0] wd;
      sc = (k % 2 == 0) ? 8'h40 : 8'h10;
      wa = 20'h0_1111 * (k + 3);
      wd = 8'h17 * (k + 1);
      base = hs_count;
      host_write('0, sc);
      host_write(wa, wd);
      chk($sformatf("R5 write count %0d", k), hs_count, base + 1);
      chk($sformatf("R5 write kind %0d", k), last_kind, 1);
      chk($sformatf("R5 write addr %0d", k), last_addr, wa);
      chk($sformatf("R5 write data %0d", k), last_data, wd);
      host_write('0, 8'hFF);
      rd_chk($sformatf("R6 read array ignored %0d", k), 20'h0_0005, 8'h00);
      host_write('0, 8'h90);
      rd_chk($sformatf("R6 ident ignored %0d", k), 20'h0_0005, 8'h00);
      finish_op(k == 1);
      rd_chk($sformatf("R14 write done %0d", k), '0, (k == 1) ? 8'h90 : 8'h80);
      host_write('0, 8'h50);
    end

    // R8 improper erase sequences
    host_write(20'h2_0000, 8'h20);
    host_write(20'h2_0000, 8'hFF);
    rd_chk("R8 improper byte", '0, 8'hB0);
    host_write('0, 8'h50);
    rd_chk("R3 clear improper", '0, 8'h80);
    base = hs_count;
    host_write(20'h2_0000, 8'h20);
    host_write(20'h4_0000, 8'hD0);
    rd_chk("R8 wrong block", '0, 8'hB0);
    chk("R8 no request", hs_count, base);
    host_write('0, 8'h50);

    // R9 low programming voltage
    vpp_high = 1'b0;
    host_write(20'h1_0000, 8'h20);
    host_write(20'h1_0000, 8'hD0);
    rd_chk("R9 erase at low vpp", '0, 8'h88);
    host_write('0, 8'h50);
    host_write('0, 8'h40);
    host_write(20'h0_0010, 8'h33);
    rd_chk("R9 write at low vpp", '0, 8'h88);
    chk("R9 no request", hs_count, base);
    host_write('0, 8'h50);
    vpp_high = 1'b1;

    // R7 R11 suspend and resume
    host_write(20'h3_0000, 8'h20);
    host_write(20'h3_0100, 8'hD0);
    base = hs_count;
    host_write('0, 8'hB0);
    chk("R7 suspend request", hs_count, base + 1);
    chk("R7 suspend kind", last_kind, 2);
    @(posedge clk); #1; eng_suspended = 1'b1;
    repeat (2) @(negedge clk);
    rd_chk("R7 suspended status", '0, 8'hC0);
    host_write('0, 8'h90);
    rd_chk("R7 ident ignored when suspended", '0, 8'hC0);
    host_write('0, 8'hFF);
    rd_chk("R11 hidden block", 20'h3_0042, 8'hFF);
    rd_chk("R11 other block", 20'h5_0042, arr_of(20'h5_0042));
    host_write('0, 8'h70);
    rd_chk("R7 status while suspended", '0, 8'hC0);
    host_write('0, 8'hFF);
    host_write('0, 8'hD0);
    chk("R7 resume request", hs_count, base + 2);
    chk("R7 resume kind", last_kind, 3);
    @(posedge clk); #1; eng_suspended = 1'b0;
    repeat (2) @(negedge clk);
    rd_chk("R7 resume reads status", '0, 8'h00);
    finish_op(1'b0);
    rd_chk("R14 resumed erase done", '0, 8'h80);

    // R13 back-pressure
    @(posedge clk); #1; req_ready = 1'b0;
    base = hs_count;
    host_write('0, 8'h10);
    host_write(20'h7_7777, 8'h5C);
    repeat (4) @(negedge clk);
    chk("R13 held valid", req_valid, 1);
    chk("R13 held kind", req_kind, 1);
    chk("R13 held addr", req_addr, 20'h7_7777);
    chk("R13 held data", req_data, 8'h5C);
    chk("R13 not taken", hs_count, base);
    @(posedge clk); #1; req_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R13 taken once", hs_count, base + 1);
    chk("R13 valid dropped", req_valid, 0);
    finish_op(1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule